// File: doc/BRIEF.md
# Dual-Register Edge Capture Unit

This block timestamps transitions on an external event pin. It watches the pin and, when a transition of the selected polarity arrives, copies the current value of a free-running counter into one of two read-only capture registers. A 2-bit edge-mode field chooses which transitions count. A pin-direction bit decides whether the pin is an input at all. A capture-mode bit selects one of two behaviours. In the first, the first qualifying event is stored. In the second, the first event is recorded and the second event is then stored alongside it, so software can read a period or pulse width directly.

When the sequence finishes, a sticky status flag is set and the unit stops taking events. Software writes 1 to the status bit to clear the flag and re-arm the unit. The interrupt request follows the flag whenever the interrupt enable is high. The pin is asynchronous to the clock, so it passes through a two-flop synchronizer before edge detection. The counter, any prescaling and the bus decoding all sit outside this block.

Top module: `edge_capture_pair`

## Requirements
- R1: The edge-mode field selects the qualifying transitions: 0 = none, 1 = low-to-high, 2 = high-to-low, 3 = either.
- R2: A pin change applied between clock edges is captured with the counter value present at the third rising clock edge after the change (two synchronizer flops, then edge detection).
- R3: With the capture-mode bit at 0, the first qualifying event loads capture register 1 and sets the status flag.
- R4: With the capture-mode bit at 1, the first qualifying event loads capture register 1 and leaves the flag clear. The second qualifying event loads capture register 2 and sets the flag.
- R5: When the pin-direction bit is 0 (pin is an output), no capture occurs and the flag does not change.
- R6: A status write with data 1 clears the flag. A status write with data 0 leaves the flag unchanged.
- R7: While the flag is set, further events are ignored and both capture registers hold their values. Once the flag is cleared, the unit re-arms for a new sequence.
- R8: If a clearing status write and a qualifying event fall in the same cycle while the flag is set, the clear takes effect and the event is dropped.
- R9: The interrupt request is high exactly when the flag is set and the interrupt enable is high.
- R10: After reset, both capture registers, the flag and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 32 | Free-running counter value to snapshot |
| evt_pin_i | input | 1 | Raw asynchronous event pin |
| edge_mode_i | input | 2 | Qualifying-edge selection (R1) |
| second_evt_i | input | 1 | 0: store first event; 1: store first and second event |
| pin_in_i | input | 1 | 1: pin is an input and capture is allowed |
| irq_en_i | input | 1 | Capture interrupt enable |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 1 | Status write data; 1 clears the flag |
| capt1_o | output | 32 | Capture register 1 |
| capt2_o | output | 32 | Capture register 2 |
| cap_flag_o | output | 1 | Capture status flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
Two functions can fall in the same cycle: a status clear and a synchronized qualifying edge, both arriving while the flag is set. The bench provokes this by timing the clearing write so that it covers exactly the clock edge at which the delayed edge reaches the sequencer. It then expects the flag to drop, the capture registers to stay unchanged and no new capture to follow. A behavioural reference model, updated on every rising edge, is compared with all outputs on every falling edge.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALF = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_CAPT = 2;
endpackage

// File: rtl/capt_rst_sync.sv
module capt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/capt_sync.sv
module capt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/capt_edge.sv
module capt_edge
  import capt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  input  logic       pin_in_i,
  output logic       evt_o
);
  logic prev_q;
  logic rise, fall, hit;
  edge_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign mode = edge_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign evt_o = hit & pin_in_i;
endmodule

// File: rtl/capt_seq.sv
module capt_seq
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             second_i,
  input  logic             wr_i,
  input  logic             wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             flag_o
);
  seq_state_e st_q, st_d;
  logic flag_q, flag_d;
  logic clr;
  logic [NUM_CAPT-1:0] cap_en;
  logic [CNT_W-1:0] cap_q [NUM_CAPT];

  assign clr = wr_i & wdata_i;

  always_comb begin
    st_d   = st_q;
    flag_d = flag_q;
    cap_en = '0;
    unique case (st_q)
      ST_IDLE: if (evt_i) begin
        cap_en[0] = 1'b1;
        if (second_i) begin
          st_d = ST_HALF;
        end else begin
          st_d   = ST_DONE;
          flag_d = 1'b1;
        end
      end
      ST_HALF: if (evt_i) begin
        cap_en[1] = 1'b1;
        st_d      = ST_DONE;
        flag_d    = 1'b1;
      end
      ST_DONE: if (clr) begin
        st_d   = ST_IDLE;
        flag_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  for (genvar g = 0; g < NUM_CAPT; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q[g] <= '0;
      else if (cap_en[g]) cap_q[g] <= count_i;
    end
  end

  assign cap1_o = cap_q[0];
  assign cap2_o = cap_q[1];
  assign flag_o = flag_q;

  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt_i)); // R3
  AST_HALF_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALF) |-> !flag_q); // R4
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_i && wdata_i) |=> !flag_q); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> ($stable(cap1_o) && $stable(cap2_o))); // R7
endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             evt_pin_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             second_evt_i,
  input  logic             pin_in_i,
  input  logic             irq_en_i,
  input  logic             stat_wr_i,
  input  logic             stat_wdata_i,
  output logic [CNT_W-1:0] capt1_o,
  output logic [CNT_W-1:0] capt2_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic rst_s_n;
  logic lvl;
  logic evt;

  capt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   (evt_pin_i),
    .q_o   (lvl)
  );

  capt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lvl_i    (lvl),
    .mode_i   (edge_mode_i),
    .pin_in_i (pin_in_i),
    .evt_o    (evt)
  );

  capt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .evt_i    (evt),
    .second_i (second_evt_i),
    .wr_i     (stat_wr_i),
    .wdata_i  (stat_wdata_i),
    .count_i  (count_i),
    .cap1_o   (capt1_o),
    .cap2_o   (capt2_o),
    .flag_o   (cap_flag_o)
  );

  assign irq_o = cap_flag_o & irq_en_i;

  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (edge_mode_i == 2'd0) |=> ($stable(capt1_o) && $stable(capt2_o))); // R1
  AST_PIN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pin_in_i |=> ($stable(capt1_o) && $stable(capt2_o) && !$rose(cap_flag_o))); // R5
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o |-> (irq_en_i && cap_flag_o)); // R9
endmodule

// File: tb/edge_capture_pair_tb.sv
module edge_capture_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt = 32'hFFFF_FF00;
  logic        pin = 1'b0;
  logic [1:0]  mode = 2'd1;
  logic        sec = 1'b0;
  logic        dir = 1'b1;
  logic        ien = 1'b1;
  logic        swr = 1'b0;
  logic        swd = 1'b0;
  logic [31:0] c1, c2;
  logic        flg, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  edge_capture_pair u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .evt_pin_i(pin),
    .edge_mode_i(mode), .second_evt_i(sec), .pin_in_i(dir),
    .irq_en_i(ien), .stat_wr_i(swr), .stat_wdata_i(swd),
    .capt1_o(c1), .capt2_o(c2), .cap_flag_o(flg), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1;

  // behavioural reference model
  int m_s1, m_s2, m_prev, m_st, m_flag;
  logic [31:0] m_c1, m_c2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0; m_flag = 0; m_c1 = 0; m_c2 = 0;
    end else begin
      bit r, f, q;
      r = (m_s2 == 1) && (m_prev == 0);
      f = (m_s2 == 0) && (m_prev == 1);
      q = dir && ((mode == 1 && r) || (mode == 2 && f) || (mode == 3 && (r || f)));
      if (m_st == 0 && q) begin
        m_c1 = cnt;
        if (sec) m_st = 1; else begin m_st = 2; m_flag = 1; end
      end else if (m_st == 1 && q) begin
        m_c2 = cnt; m_st = 2; m_flag = 1;
      end else if (m_st == 2 && swr && swd) begin
        m_st = 0; m_flag = 0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(pin);
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] m_irq;
      m_irq = (m_flag != 0 && ien) ? 32'd1 : 32'd0;
      chk(c1 == m_c1, "R3/R4 model capt1", c1, m_c1);
      chk(c2 == m_c2, "R4 model capt2", c2, m_c2);
      chk(flg == (m_flag != 0), "R6/R7 model flag", {31'd0, flg}, m_flag);
      chk(irq == m_irq[0], "R9 model irq", {31'd0, irq}, m_irq);
    end
  end

  logic [31:0] k;
  task automatic drive_pin(bit v);
    @(negedge clk); #1; pin = v; k = cnt;
  endtask
  task automatic settle();
    repeat (3) @(negedge clk); #2;
  endtask
  task automatic clear(bit d);
    @(negedge clk); #1; swr = 1'b1; swd = d;
    @(negedge clk); #1; swr = 1'b0; swd = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk(c1 == 0 && c2 == 0, "R10 reset capt", c1 | c2, 0);
    chk(!flg && !irq, "R10 reset flag/irq", {30'd0, flg, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3, R2: first-event, rising edges
    drive_pin(1); settle();
    chk(c1 == k + 2, "R2 capture latency", c1, k + 2);
    chk(flg == 1, "R3 flag set", {31'd0, flg}, 1);
    chk(irq == 1, "R9 irq high", {31'd0, irq}, 1);
    ien = 1'b0; #1;
    chk(irq == 0, "R9 irq masked", {31'd0, irq}, 0);
    ien = 1'b1;

    // R7: events ignored while flag set
    held = c1; mode = 2'd3;
    drive_pin(0); settle(); drive_pin(1); settle();
    chk(c1 == held, "R7 hold while set", c1, held);

    // R6: write 0 keeps, write 1 clears
    clear(0); #1;
    chk(flg == 1, "R6 write0 no effect", {31'd0, flg}, 1);
    clear(1); #1;
    chk(flg == 0, "R6 write1 clears", {31'd0, flg}, 0);

    // R1: falling-only mode; pin currently high
    mode = 2'd2;
    drive_pin(0); settle();
    chk(flg == 1 && c1 == k + 2, "R1 falling edge captured", c1, k + 2);
    clear(1);
    drive_pin(1); settle();
    chk(flg == 0, "R1 rising ignored in fall mode", {31'd0, flg}, 0);

    // R1: mode off
    mode = 2'd0; held = c1;
    drive_pin(0); settle(); drive_pin(1); settle();
    chk(flg == 0 && c1 == held, "R1 mode off", c1, held);

    // R5: pin as output
    mode = 2'd3; dir = 1'b0;
    drive_pin(0); settle(); drive_pin(1); settle();
    chk(flg == 0 && c1 == held, "R5 output pin no capture", c1, held);
    dir = 1'b1;

    // R4: second-event mode, both edges
    sec = 1'b1;
    drive_pin(0); settle();
    chk(c1 == k + 2, "R4 first event in capt1", c1, k + 2);
    chk(flg == 0, "R4 flag clear after first", {31'd0, flg}, 0);
    drive_pin(1); settle();
    chk(c2 == k + 2, "R4 second event in capt2", c2, k + 2);
    chk(flg == 1, "R4 flag after second", {31'd0, flg}, 1);

    // R8: clear and event in same cycle
    sec = 1'b0; held = c1;
    drive_pin(0);
    @(negedge clk); @(negedge clk); #1; swr = 1'b1; swd = 1'b1;
    @(negedge clk); #1; swr = 1'b0; swd = 1'b0;
    repeat (3) @(negedge clk); #2;
    chk(flg == 0, "R8 clear wins", {31'd0, flg}, 0);
    chk(c1 == held, "R8 event dropped", c1, held);

    // R7: re-armed after clear
    drive_pin(1); settle();
    chk(flg == 1 && c1 == k + 2, "R7 rearm capture", c1, k + 2);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule